// File: doc/BRIEF.md
# Retriggerable Interval Timer Channel

This block is one channel of a general-purpose timer. A 16-bit up-counter advances by one whenever a count-enable pulse from an external clock selector arrives while the channel's clock is running. The counter restarts from zero on a trigger. A trigger can come from a command written through the register port, from a broadcast SYNC input shared by several channels, from an asynchronous external event pin, or from the counter itself reaching a programmable reload value. In the last case the channel counts repeatedly through a fixed period, which makes it a periodic interrupt source.

A trigger never zeroes the counter in the cycle it occurs. It is held pending, and the counter takes zero on the next count-enable pulse that finds the clock running. Events are collected in a sticky status register that clears when it is read. A write-one-to-set port and a write-one-to-clear port maintain an interrupt mask over the status register, and a single interrupt line reports any status bit that is both set and unmasked. The live count can be read at any time without disturbing counting.

Top module: `tmr_chan`

## Requirements
- R1: After synchronous reset the counter, status, mask, mode and reload value are zero, the channel clock is stopped, and `irq` is low.
- R2: While the channel clock runs, each cycle with `cnt_tick` high adds one to the counter. Without `cnt_tick`, or while the clock is stopped, the counter holds its value.
- R3: An advance from 0xFFFF to 0x0000 sets status bit 0 (overflow).
- R4: Writing address 0 with bit 2 set is a software trigger. It sets status bit 3. The counter is not cleared in the trigger cycle. It becomes 0 on the first later cycle in which `cnt_tick` is high and the clock runs, and counting resumes from there.
- R5: A cycle with `sync_in` high has the same effect as a software trigger, including setting status bit 3.
- R6: When an advance makes the counter equal to the reload value (address 2), status bit 1 is set. If mode bit 0 (address 1) is set, that match is also a trigger, so the counter repeats a period of reload+1 ticks.
- R7: `ext_evt` passes through a two-stage synchronizer and a rising-edge detector. Each detected edge sets status bit 2, and it acts as a trigger only while mode bit 1 is set.
- R8: Writing address 0 with bit 0 starts the channel clock. Bit 1 stops it and locks it, and bit 1 wins when both are set. A trigger starts a stopped clock unless it is locked. Address 7 reads {lock, running} in bits [1:0].
- R9: Writing address 3 sets the mask bits written as 1. Writing address 4 clears the mask bits written as 1. Other mask bits keep their value. The mask reads at address 6.
- R10: Status bits are sticky. They read at address 5, and a read strobe (`rd_en`) at address 5 clears them, except that an event in that same cycle is kept.
- R11: `irq` is high exactly when some status bit and the same mask bit are both 1.
- R12: Address 0 returns the live counter value, and reading it does not change counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count-enable pulse from the clock selector |
| sync_in | input | 1 | Broadcast trigger shared by channels |
| ext_evt | input | 1 | Asynchronous external trigger event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Read strobe; clears status when at address 5 |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The counter is first driven with a continuous tick stream and then with gapped ticks, which separates incrementing from holding. Triggers are applied in the same cycle as a tick, which shows whether the clear is deferred or immediate. A reload of 3 with compare-triggering on checks that the period is exactly four ticks, while a run of 65536 ticks checks the wrap. External edges are applied with the external enable both off and on, so that status-only behaviour can be told apart from a real restart. A stop followed by a software trigger checks that the lock holds against restarts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int IRQ_N  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT  = 3'd0,
        A_MODE = 3'd1,
        A_RC   = 3'd2,
        A_IEN  = 3'd3,
        A_IDIS = 3'd4,
        A_STAT = 3'd5,
        A_MASK = 3'd6,
        A_CLK  = 3'd7
    } addr_e;

    localparam int CMD_ON  = 0;
    localparam int CMD_OFF = 1;
    localparam int CMD_TRG = 2;

    localparam int ST_OVF = 0;
    localparam int ST_RCM = 1;
    localparam int ST_EXT = 2;
    localparam int ST_TRG = 3;

    typedef struct packed {
        logic ext_en;
        logic cmp_en;
    } mode_t;

    typedef struct packed {
        logic on;
        logic off;
        logic trg;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic wr, input logic [2:0] bits);
        cmd_t c;
        c.on  = wr & bits[CMD_ON];
        c.off = wr & bits[CMD_OFF];
        c.trg = wr & bits[CMD_TRG];
        return c;
    endfunction
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sr;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            last <= 1'b0;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) sr[i] <= sr[i-1];
            sr[0] <= async_in;
            last  <= sr[STAGES-1];
        end
    end

    assign rise = sr[STAGES-1] & ~last;

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         clk_on,
    input  logic         clk_off,
    input  logic         trig,
    input  logic         cmp_en,
    input  logic [W-1:0] rc,
    output logic [W-1:0] cnt,
    output logic         running,
    output logic         locked,
    output logic         ovf_evt,
    output logic         hit_evt
);
    logic [W-1:0] cnt_q, nxt;
    logic         pend_q, run_q, lock_q, adv;

    assign adv     = tick & run_q;
    assign nxt     = pend_q ? '0 : cnt_q + 1'b1;
    assign ovf_evt = adv & ~pend_q & (cnt_q == '1);
    assign hit_evt = adv & (nxt == rc);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
            run_q  <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (adv) cnt_q <= nxt;
            pend_q <= (pend_q & ~adv) | trig | (hit_evt & cmp_en);
            if (clk_off) begin
                run_q  <= 1'b0;
                lock_q <= 1'b1;
            end else if (clk_on) begin
                run_q  <= 1'b1;
                lock_q <= 1'b0;
            end else if (trig && !lock_q) begin
                run_q  <= 1'b1;
            end
        end
    end

    assign cnt     = cnt_q;
    assign running = run_q;
    assign locked  = lock_q;

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
    assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> (cnt_q == '0));
    assert_trig_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (trig && !lock_q && !clk_off) |=> run_q);
    assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !clk_on) |=> !run_q);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic         clr_rd,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] st_q, mk_q, st_d, mk_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign st_d[i] = set_vec[i] | (st_q[i] & ~clr_rd);
        assign mk_d[i] = (mk_q[i] | (en_wr & wdata[i])) & ~(dis_wr & wdata[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            mk_q <= '0;
        end else begin
            st_q <= st_d;
            mk_q <= mk_d;
        end
    end

    assign status = st_q;
    assign mask   = mk_q;
    assign irq    = |(st_q & mk_q);

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !clr_rd |=> ((st_q & $past(st_q)) == $past(st_q)));
    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (rst)
        set_vec[0] |=> st_q[0]);
    assert_full_disable_R11: assert property (@(posedge clk) disable iff (rst)
        (dis_wr && (&wdata)) |=> !irq);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_WIDTH   = CNT_W,
    parameter int N_IRQ       = IRQ_N,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_tick,
    input  logic                 sync_in,
    input  logic                 ext_evt,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_WIDTH-1:0] wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_WIDTH-1:0] rd_data,
    output logic                 irq
);
    mode_t                mode_q;
    logic [CNT_WIDTH-1:0] rc_q, cnt;
    logic [N_IRQ-1:0]     status, mask, set_vec;
    logic                 ext_rise, sw_or_sync, trig, running, locked, ovf_evt, hit_evt;
    cmd_t                 cmd;
    logic                 unused_bits;

    assign cmd         = decode_cmd(wr_en && addr_e'(wr_addr) == A_CNT, wr_data[2:0]);
    assign unused_bits = ^wr_data[CNT_WIDTH-1:N_IRQ];

    tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(ext_evt), .rise(ext_rise)
    );

    assign sw_or_sync = cmd.trg | sync_in;
    assign trig       = sw_or_sync | (ext_rise & mode_q.ext_en);

    tmr_counter #(.W(CNT_WIDTH)) u_cnt (
        .clk(clk), .rst(rst), .tick(cnt_tick),
        .clk_on(cmd.on), .clk_off(cmd.off), .trig(trig),
        .cmp_en(mode_q.cmp_en), .rc(rc_q),
        .cnt(cnt), .running(running), .locked(locked),
        .ovf_evt(ovf_evt), .hit_evt(hit_evt)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[ST_OVF] = ovf_evt;
        set_vec[ST_RCM] = hit_evt;
        set_vec[ST_EXT] = ext_rise;
        set_vec[ST_TRG] = sw_or_sync;
    end

    tmr_irq #(.N(N_IRQ)) u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_rd(rd_en && addr_e'(rd_addr) == A_STAT),
        .en_wr(wr_en && addr_e'(wr_addr) == A_IEN),
        .dis_wr(wr_en && addr_e'(wr_addr) == A_IDIS),
        .wdata(wr_data[N_IRQ-1:0]),
        .status(status), .mask(mask), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            rc_q   <= '0;
        end else if (wr_en) begin
            if (addr_e'(wr_addr) == A_MODE) mode_q <= mode_t'(wr_data[1:0]);
            if (addr_e'(wr_addr) == A_RC)   rc_q   <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr_e'(rd_addr))
            A_CNT:   rd_data = cnt;
            A_MODE:  rd_data[1:0] = mode_q;
            A_RC:    rd_data = rc_q;
            A_STAT:  rd_data[N_IRQ-1:0] = status;
            A_MASK:  rd_data[N_IRQ-1:0] = mask;
            A_CLK:   rd_data[1:0] = {locked, running};
            default: rd_data = '0;
        endcase
    end

    assert_reload_flag_R6: assert property (@(posedge clk) disable iff (rst)
        hit_evt |=> status[ST_RCM]);
    assert_sync_flag_R5: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> status[ST_TRG]);
endmodule

// File: tb/tmr_chan_bench.sv
`timescale 1ns/1ps
module tmr_chan_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_tick = 1'b0, sync_in = 1'b0, ext_evt = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    tmr_chan u_tmr_chan (
        .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .sync_in(sync_in), .ext_evt(ext_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference model
    int m_cnt, m_rc, m_mode, m_mask, m_st;
    bit m_pend, m_run, m_lock, m_s1, m_s2, m_s3;

    function automatic int model_read(input int a);
        case (a)
            0: return m_cnt;
            1: return m_mode;
            2: return m_rc;
            5: return m_st;
            6: return m_mask;
            7: return (int'(m_lock) << 1) | int'(m_run);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R12";
            1, 2: return "R6";
            5: return "R10";
            6: return "R9";
            7: return "R8";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rc = 0; m_mode = 0; m_mask = 0; m_st = 0;
            m_pend = 0; m_run = 0; m_lock = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit sw, on, off, e, trg, adv, np;
            int setv, nc;
            sw  = wr_en && wr_addr == 0 && wr_data[2];
            on  = wr_en && wr_addr == 0 && wr_data[0];
            off = wr_en && wr_addr == 0 && wr_data[1];
            e   = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_evt;
            trg  = sw || sync_in || (e && m_mode[1]);
            setv = 0;
            if (sw || sync_in) setv |= 8;
            if (e) setv |= 4;
            adv = cnt_tick && m_run;
            np  = m_pend && !adv;
            if (adv) begin
                if (m_pend) nc = 0;
                else begin
                    nc = (m_cnt + 1) & 16'hFFFF;
                    if (m_cnt == 16'hFFFF) setv |= 1;
                end
                if (nc == m_rc) begin
                    setv |= 2;
                    if (m_mode[0]) np = 1;
                end
                m_cnt = nc;
            end
            if (trg) np = 1;
            m_pend = np;
            if (off) begin m_run = 0; m_lock = 1; end
            else if (on) begin m_run = 1; m_lock = 0; end
            else if (trg && !m_lock) m_run = 1;
            if (rd_en && rd_addr == 5) m_st = setv; else m_st |= setv;
            if (wr_en && wr_addr == 1) m_mode = wr_data[1:0];
            if (wr_en && wr_addr == 2) m_rc = wr_data;
            if (wr_en && wr_addr == 3) m_mask |= wr_data[7:0];
            if (wr_en && wr_addr == 4) m_mask &= ~int'(wr_data[7:0]);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(tag_of(rd_addr), rd_data, model_read(rd_addr));
            check("R11", irq, (m_st & m_mask) != 0);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = a[2:0]; wr_data = d[15:0];
        cyc();
        wr_en = 0;
    endtask

    task automatic expect_rd(input int a, input int exp, input string tag);
        rd_addr = a[2:0]; #1;
        check(tag, rd_data, exp);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        // R1 reset state
        expect_rd(0, 0, "R1 counter");
        expect_rd(5, 0, "R1 status");
        expect_rd(6, 0, "R1 mask");
        expect_rd(7, 0, "R1 clock");
        check("R1 irq", irq, 0);
        // R2 stopped clock ignores ticks
        cnt_tick = 1; repeat (4) cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R2 stopped");
        wr(0, 1);
        cnt_tick = 1; repeat (5) cyc(); cnt_tick = 0;
        expect_rd(0, 5, "R2 count");
        repeat (3) cyc();
        expect_rd(0, 5, "R2 hold");
        // R4 deferred clear
        cnt_tick = 1; wr(0, 4);
        expect_rd(0, 6, "R4 not same cycle");
        cyc();
        expect_rd(0, 0, "R4 cleared");
        cyc(); cnt_tick = 0;
        expect_rd(0, 1, "R4 restart");
        // R5 sync
        sync_in = 1; cyc(); sync_in = 0;
        expect_rd(0, 1, "R5 deferred");
        cnt_tick = 1; cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R5 cleared");
        // R6 reload period
        wr(2, 3); wr(1, 1);
        cnt_tick = 1; repeat (4) cyc();
        expect_rd(0, 0, "R6 period");
        repeat (3) cyc(); cnt_tick = 0;
        expect_rd(0, 3, "R6 reach");
        rd_addr = 5; #1; check("R6 flag", rd_data[1], 1);
        rd_en = 1; cyc(); rd_en = 0;
        expect_rd(5, 0, "R10 clear");
        // R9 / R11
        wr(3, 2);
        check("R11 idle", irq, 0);
        cnt_tick = 1; repeat (4) cyc(); cnt_tick = 0;
        check("R11 raised", irq, 1);
        wr(4, 2);
        expect_rd(6, 0, "R9 disable");
        check("R9 masked", irq, 0);
        wr(3, 2);
        check("R9 enable", irq, 1);
        rd_addr = 5; rd_en = 1; sync_in = 1; cyc(); rd_en = 0; sync_in = 0;
        expect_rd(5, 8, "R10 same-cycle event");
        check("R11 cleared", irq, 0);
        // R7 external trigger
        wr(1, 0);
        cnt_tick = 1; cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R7 prep");
        cnt_tick = 1; repeat (2) cyc(); cnt_tick = 0;
        ext_evt = 1; repeat (4) cyc(); ext_evt = 0;
        cnt_tick = 1; cyc(); cnt_tick = 0;
        expect_rd(0, 3, "R7 ignored");
        rd_addr = 5; #1; check("R7 flag", rd_data[2], 1);
        wr(1, 2);
        ext_evt = 1; repeat (4) cyc(); ext_evt = 0;
        cnt_tick = 1; cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R7 enabled");
        // R8 lock
        wr(0, 2);
        cnt_tick = 1; repeat (3) cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R8 stopped");
        expect_rd(7, 2, "R8 locked");
        wr(0, 4);
        cnt_tick = 1; repeat (2) cyc(); cnt_tick = 0;
        expect_rd(7, 2, "R8 trigger blocked");
        wr(0, 1);
        cnt_tick = 1; repeat (2) cyc(); cnt_tick = 0;
        expect_rd(0, 1, "R8 resumed");
        // R3 overflow with live reads (R12)
        rd_addr = 0;
        cnt_tick = 1; repeat (65534) cyc(); cnt_tick = 0;
        expect_rd(0, 16'hFFFF, "R12 live top");
        cnt_tick = 1; cyc(); cnt_tick = 0;
        expect_rd(0, 0, "R3 wrap");
        rd_addr = 5; #1; check("R3 flag", rd_data[0], 1);
        repeat (2) cyc();
        summary();
    end
endmodule